// File: doc/BRIEF.md
# Prioritized Level Interrupt Controller

This block is the root interrupt controller of a small multiprocessor. It takes a set of level-sensitive hardware interrupt lines, combines each one with a software trigger bit, gates it with a per-line mask and steers it to one or more CPUs through a per-line CPU bitmask. Each CPU has one interrupt request output that is high while any line is eligible for it.

Software reaches the block over a simple 32-bit register bus whose every access also carries the index of the CPU that makes it. A CPU services interrupts by reading its event register. That read returns a word naming the lowest-numbered eligible line, and it masks that line in the same clock edge. Software therefore unmasks the line when it has finished its handler. Because inputs are levels, a line that is still asserted when unmasked is delivered again.

Top module: `prio_level_intc`

## Requirements
- R1: A read of the event register (offset 0x2004) that finds an eligible line n for the accessing CPU returns bits 31:16 = 1 (hardware kind) and bits 15:0 = n. The word appears on bus_rdata_o in the cycle after the read strobe.
- R2: The event read that delivers line n sets mask bit n at the same clock edge. If no other line is eligible, that CPU's request output is low from the next cycle.
- R3: When several lines are eligible for the accessing CPU, the event read delivers the lowest-numbered one.
- R4: Mask bits are written 1-to-set at 0x4100 + 4*(n>>5) and 1-to-clear at 0x4180 + 4*(n>>5), with bit n&31 in the word. Zero bits leave the mask unchanged. Either address reads back the current mask word.
- R5: Software trigger bits use the same word and bit layout, 1-to-set at 0x4000 and 1-to-clear at 0x4080. Each bit is ORed with its hardware line to form the raw pending state, and either address reads back the current word.
- R6: Line n has a target register at 0x3000 + 4*n. Bits [NUM_CPUS-1:0] of that register are a CPU bitmask, and the line is eligible only on CPUs whose bit is set. The register reads back its value zero-extended.
- R7: irq_o[c] is high in the same cycle exactly when some line has (hardware OR software) AND NOT mask AND target bit c.
- R8: After reset every mask bit is 1, every software bit is 0 and every target register holds 1 (CPU 0 only), so no request output is high.
- R9: A line whose hardware input is still high when its mask is cleared becomes eligible again and is delivered again.
- R10: An event read that finds no eligible line for the accessing CPU returns 0 and changes no mask bit.
- R11: Offset 0x0004 returns NUM_LINES in bits 15:0. Offset 0x2000 returns the index of the accessing CPU.
- R12: A read of any offset other than the event register changes no mask, software or target state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq_i | input | NUM_LINES (64) | Level-sensitive hardware interrupt lines |
| bus_valid_i | input | 1 | Bus access strobe, one cycle per access |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_cpu_i | input | CPU_W (2) | Index of the CPU making the access |
| bus_addr_i | input | 16 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read strobe and held until the next read |
| irq_o | output | NUM_CPUS (4) | Per-CPU interrupt request |

## Verification
Register state, including the mask bit set by an event read, changes at the edge that samples the strobe. Read data is registered at that same edge, so the bench drives each access on a falling edge and samples bus_rdata_o on the following falling edge. irq_o depends combinationally on state and on the hardware lines. The bench checks it 1 ns after each falling edge at which it changed a hardware line or after which a bus access finished. The expected event word is computed from the bench model at the moment the strobe is driven, and the model then masks the delivered line, mirroring the edge at which the design does so.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam logic [15:0] OFS_INFO     = 16'h0004;
  localparam logic [15:0] OFS_WHOAMI   = 16'h2000;
  localparam logic [15:0] OFS_EVENT    = 16'h2004;
  localparam logic [15:0] OFS_TARGET   = 16'h3000;
  localparam logic [15:0] OFS_SW_SET   = 16'h4000;
  localparam logic [15:0] OFS_SW_CLR   = 16'h4080;
  localparam logic [15:0] OFS_MASK_SET = 16'h4100;
  localparam logic [15:0] OFS_MASK_CLR = 16'h4180;

  localparam logic [15:0] EVT_KIND_HW = 16'd1;

  typedef struct packed {
    logic [15:0] kind;
    logic [15:0] num;
  } evt_word_t;

  // Build the event word for a delivered hardware line.
  function automatic evt_word_t make_hw_event(input logic [15:0] line);
    evt_word_t w;
    w.kind = EVT_KIND_HW;
    w.num  = line;
    return w;
  endfunction

  // Word-aligned address inside [base, base + 4*nwords).
  function automatic logic in_window(input logic [15:0] addr,
                                     input logic [15:0] base,
                                     input int unsigned nwords);
    int unsigned a;
    int unsigned b;
    a = 32'(addr);
    b = 32'(base);
    return (a >= b) && (a < b + 4 * nwords) && (addr[1:0] == 2'b00);
  endfunction

  // Word number of an address inside a window.
  function automatic int unsigned word_of(input logic [15:0] addr,
                                          input logic [15:0] base);
    return (32'(addr) - 32'(base)) >> 2;
  endfunction

endpackage

// File: rtl/intc_state.sv
module intc_state
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPUS  = 4,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [15:0]                          wr_addr,
  input  logic [31:0]                          wr_data,
  input  logic                                 ack_en,
  input  logic [IDX_W-1:0]                     ack_idx,
  output logic [NUM_LINES-1:0]                 mask_o,
  output logic [NUM_LINES-1:0]                 sw_o,
  output logic [NUM_LINES-1:0][NUM_CPUS-1:0]   target_o
);

  logic [NUM_LINES-1:0] mask_q, sw_q;
  logic [NUM_LINES-1:0] mask_set, mask_clr, sw_set, sw_clr, ack_vec;

  // Per-line set/clear strobes from the word-organised write registers.
  always_comb begin
    mask_set = '0;
    mask_clr = '0;
    sw_set   = '0;
    sw_clr   = '0;
    for (int n = 0; n < NUM_LINES; n++) begin
      if (wr_en && wr_data[n % 32]) begin
        if (wr_addr == 16'(32'(OFS_MASK_SET) + 4 * (n / 32))) mask_set[n] = 1'b1;
        if (wr_addr == 16'(32'(OFS_MASK_CLR) + 4 * (n / 32))) mask_clr[n] = 1'b1;
        if (wr_addr == 16'(32'(OFS_SW_SET)   + 4 * (n / 32))) sw_set[n]   = 1'b1;
        if (wr_addr == 16'(32'(OFS_SW_CLR)   + 4 * (n / 32))) sw_clr[n]   = 1'b1;
      end
    end
  end

  // Auto-acknowledge: one-hot mask set for the delivered line.
  always_comb begin
    ack_vec = '0;
    if (ack_en) ack_vec[ack_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      sw_q   <= '0;
    end else begin
      mask_q <= (mask_q | mask_set | ack_vec) & ~mask_clr;
      sw_q   <= (sw_q | sw_set) & ~sw_clr;
    end
  end

  // One target register per line, reset to CPU 0.
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_target
    logic [NUM_CPUS-1:0] tgt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tgt_q <= NUM_CPUS'(1);
      else if (wr_en && wr_addr == 16'(32'(OFS_TARGET) + 4 * n))
        tgt_q <= wr_data[NUM_CPUS-1:0];
    end
    assign target_o[n] = tgt_q;
  end

  assign mask_o = mask_q;
  assign sw_o   = sw_q;

  // R2
  ack_masks_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en |=> mask_q[$past(ack_idx)]);

  // R4
  mask_clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (($past(mask_q) & ~mask_q) == '0));

endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int NUM_LINES = 64,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] cand_i,
  output logic                 hit_o,
  output logic [IDX_W-1:0]     idx_o
);

  // Lowest set position; scanning downward lets the lowest one win.
  function automatic logic [IDX_W-1:0] lowest_set(input logic [NUM_LINES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  assign hit_o = |cand_i;
  assign idx_o = lowest_set(cand_i);

endmodule

// File: rtl/prio_level_intc.sv
module prio_level_intc
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPUS  = 4,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int NUM_WORDS = (NUM_LINES + 31) / 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] hw_irq_i,
  input  logic                 bus_valid_i,
  input  logic                 bus_write_i,
  input  logic [CPU_W-1:0]     bus_cpu_i,
  input  logic [15:0]          bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  output logic [NUM_CPUS-1:0]  irq_o
);

  localparam logic [NUM_LINES-1:0] LINE_ONE = NUM_LINES'(1);

  logic [NUM_LINES-1:0]               mask_w, sw_w, raw_w;
  logic [NUM_LINES-1:0][NUM_CPUS-1:0] tgt_w;
  logic [NUM_CPUS-1:0][NUM_LINES-1:0] cand_w;
  logic [NUM_CPUS-1:0]                pick_hit;
  logic [NUM_CPUS-1:0][IDX_W-1:0]     pick_idx;

  // Named bus events.
  logic wr_en, rd_en, evt_rd, cpu_ok, sel_hit, ack_en;
  logic [IDX_W-1:0] sel_idx;
  logic [31:0] rd_value, rdata_q;

  assign wr_en  = bus_valid_i && bus_write_i;
  assign rd_en  = bus_valid_i && !bus_write_i;
  assign evt_rd = rd_en && (bus_addr_i == OFS_EVENT);
  assign cpu_ok = 32'(bus_cpu_i) < NUM_CPUS;

  intc_state #(
    .NUM_LINES(NUM_LINES),
    .NUM_CPUS (NUM_CPUS)
  ) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (bus_addr_i),
    .wr_data (bus_wdata_i),
    .ack_en  (ack_en),
    .ack_idx (sel_idx),
    .mask_o  (mask_w),
    .sw_o    (sw_w),
    .target_o(tgt_w)
  );

  assign raw_w = hw_irq_i | sw_w;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      assign cand_w[c][n] = raw_w[n] & ~mask_w[n] & tgt_w[n][c];
    end

    intc_pick #(.NUM_LINES(NUM_LINES)) u_pick (
      .cand_i(cand_w[c]),
      .hit_o (pick_hit[c]),
      .idx_o (pick_idx[c])
    );

    assign irq_o[c] = pick_hit[c];

    // R3
    pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pick_hit[c] |-> (cand_w[c][pick_idx[c]] &&
                       ((cand_w[c] & ((LINE_ONE << pick_idx[c]) - LINE_ONE)) == '0)));
  end

  assign sel_hit = cpu_ok && pick_hit[bus_cpu_i];
  assign sel_idx = pick_idx[bus_cpu_i];
  assign ack_en  = evt_rd && sel_hit;

  // Gather one 32-bit word of a per-line vector.
  function automatic logic [31:0] word_slice(input logic [NUM_LINES-1:0] v,
                                             input int unsigned w);
    logic [31:0] r;
    r = '0;
    for (int n = 0; n < NUM_LINES; n++)
      if (n / 32 == int'(w)) r[n % 32] = v[n];
    return r;
  endfunction

  always_comb begin
    rd_value = '0;
    if (bus_addr_i == OFS_INFO) begin
      rd_value[15:0] = 16'(NUM_LINES);
    end else if (bus_addr_i == OFS_WHOAMI) begin
      rd_value = 32'(bus_cpu_i);
    end else if (bus_addr_i == OFS_EVENT) begin
      if (sel_hit) rd_value = make_hw_event(16'(sel_idx));
    end else if (in_window(bus_addr_i, OFS_TARGET, NUM_LINES)) begin
      for (int n = 0; n < NUM_LINES; n++)
        if (n == int'(word_of(bus_addr_i, OFS_TARGET)))
          rd_value[NUM_CPUS-1:0] = tgt_w[n];
    end else if (in_window(bus_addr_i, OFS_SW_SET, NUM_WORDS)) begin
      rd_value = word_slice(sw_w, word_of(bus_addr_i, OFS_SW_SET));
    end else if (in_window(bus_addr_i, OFS_SW_CLR, NUM_WORDS)) begin
      rd_value = word_slice(sw_w, word_of(bus_addr_i, OFS_SW_CLR));
    end else if (in_window(bus_addr_i, OFS_MASK_SET, NUM_WORDS)) begin
      rd_value = word_slice(mask_w, word_of(bus_addr_i, OFS_MASK_SET));
    end else if (in_window(bus_addr_i, OFS_MASK_CLR, NUM_WORDS)) begin
      rd_value = word_slice(mask_w, word_of(bus_addr_i, OFS_MASK_CLR));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_value;
  end

  assign bus_rdata_o = rdata_q;

  // R1
  evt_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && cpu_ok && irq_o[bus_cpu_i]) |=> (bus_rdata_o[31:16] == EVT_KIND_HW));

  // R10
  evt_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && cpu_ok && !irq_o[bus_cpu_i]) |=> (bus_rdata_o == '0 && $stable(mask_w)));

  // R12
  passive_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr_i != OFS_EVENT) |=> ($stable(mask_w) && $stable(sw_w) && $stable(tgt_w)));

endmodule

// File: tb/tb_prio_level_intc.sv
`timescale 1ns/1ps
module tb_prio_level_intc;

  localparam int L = 64;
  localparam int C = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [L-1:0] hw = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_cpu = '0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [C-1:0] irq;

  int nchk = 0;
  int nerr = 0;

  // Bench model of the register state.
  logic [L-1:0] m_mask = '1;
  logic [L-1:0] m_sw = '0;
  logic [C-1:0] m_tgt [L];

  always #2.5 clk = ~clk;

  prio_level_intc dut (
    .clk(clk), .rst_n(rst_n), .hw_irq_i(hw),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_cpu_i(bus_cpu),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic eligible(input int n, input int cpu);
    return (hw[n] || m_sw[n]) && !m_mask[n] && m_tgt[n][cpu];
  endfunction

  function automatic logic [C-1:0] model_irq();
    logic [C-1:0] r = '0;
    for (int cpu = 0; cpu < C; cpu++)
      for (int n = 0; n < L; n++)
        if (eligible(n, cpu)) r[cpu] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] model_event(input int cpu);
    int n = 0;
    while (n < L && !eligible(n, cpu)) n++;
    if (n == L) return 32'h0;
    return {16'h0001, 16'(n)};
  endfunction

  function automatic logic [31:0] model_read(input logic [15:0] a, input int cpu);
    int w;
    if (a == 16'h0004) return 32'(L);
    if (a == 16'h2000) return 32'(cpu);
    if (a >= 16'h3000 && a < 16'h3100 && a[1:0] == 0) return 32'(m_tgt[(a - 16'h3000) >> 2]);
    w = int'(a[2]);
    if (a[15:3] == 13'h0800 || a[15:3] == 13'h0810) return m_sw[w*32 +: 32];
    if (a[15:3] == 13'h0820 || a[15:3] == 13'h0830) return m_mask[w*32 +: 32];
    return 32'h0;
  endfunction

  function automatic void model_write(input logic [15:0] a, input logic [31:0] d);
    int w = int'(a[2]);
    if (a >= 16'h3000 && a < 16'h3100 && a[1:0] == 0) m_tgt[(a - 16'h3000) >> 2] = d[C-1:0];
    if (a[15:3] == 13'h0800) m_sw[w*32 +: 32]   = m_sw[w*32 +: 32] | d;
    if (a[15:3] == 13'h0810) m_sw[w*32 +: 32]   = m_sw[w*32 +: 32] & ~d;
    if (a[15:3] == 13'h0820) m_mask[w*32 +: 32] = m_mask[w*32 +: 32] | d;
    if (a[15:3] == 13'h0830) m_mask[w*32 +: 32] = m_mask[w*32 +: 32] & ~d;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input int cpu);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_cpu = 2'(cpu);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [15:0] a, input int cpu, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_cpu = 2'(cpu);
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_check(input string req, input logic [15:0] a, input int cpu);
    logic [31:0] got;
    logic [31:0] exp;
    exp = model_read(a, cpu);
    rd(a, cpu, got);
    check(req, got, exp);
  endtask

  task automatic evt(input string req, input int cpu);
    logic [31:0] got;
    logic [31:0] exp;
    exp = model_event(cpu);
    rd(16'h2004, cpu, got);
    check(req, got, exp);
    if (exp != 0) m_mask[exp[5:0]] = 1'b1;
  endtask

  task automatic chk_irq(input string req);
    #1;
    check(req, 32'(irq), 32'(model_irq()));
  endtask

  initial begin
    #(200000 * 5);
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] got;
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < L; n++) m_tgt[n] = 4'b0001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset state
    hw = '1;
    chk_irq("R8 irq masked after reset");
    rd_check("R8 mask word0", 16'h4100, 0);
    rd_check("R8 mask word1", 16'h4184, 0);
    rd_check("R8 sw word", 16'h4000, 0);
    rd_check("R8 target line7", 16'h301c, 0);
    // R11 info and identity
    rd_check("R11 info", 16'h0004, 1);
    rd_check("R11 whoami", 16'h2000, 3);
    evt("R10 event empty after reset", 0);
    hw = '0;

    // R7 / R1 / R2: single line 5 to CPU 0
    hw[5] = 1'b1;
    wr(16'h4180, 32'h20, 0);
    chk_irq("R7 irq line5");
    evt("R1 event line5", 0);
    chk_irq("R2 irq drops after ack");
    rd_check("R2 mask bit5 set", 16'h4100, 0);
    evt("R10 event empty after ack", 0);
    rd_check("R10 mask unchanged", 16'h4100, 0);
    // R9 level redelivery
    wr(16'h4180, 32'h20, 0);
    chk_irq("R9 irq again after unmask");

    // R3 priority: lines 5 and 40
    hw[40] = 1'b1;
    wr(16'h4184, 32'h100, 0);
    evt("R3 lowest first", 0);
    evt("R3 next line", 0);
    evt("R3 drained", 0);

    // R6 routing of line 40 to CPU 2
    wr(16'h30a0, 32'h4, 0);
    rd_check("R6 target readback", 16'h30a0, 0);
    wr(16'h4184, 32'h100, 0);
    chk_irq("R6 irq on cpu2 only");
    evt("R6 cpu0 sees nothing", 0);
    evt("R6 cpu2 gets line40", 2);

    // R5 software trigger on line 63
    hw = '0;
    wr(16'h4004, 32'h8000_0000, 1);
    rd_check("R5 sw readback", 16'h4084, 1);
    wr(16'h4184, 32'h8000_0000, 1);
    chk_irq("R5 sw raises irq");
    wr(16'h4084, 32'h8000_0000, 1);
    chk_irq("R5 sw clear drops irq");
    rd_check("R5 sw cleared", 16'h4004, 1);

    // R4 mask set/clear leave zero bits alone
    wr(16'h4180, 32'h0000_00f0, 0);
    wr(16'h4100, 32'h0000_0030, 0);
    rd_check("R4 mask word0", 16'h4180, 0);

    // R12 passive reads
    hw[6] = 1'b1;
    chk_irq("R12 irq before reads");
    rd_check("R12 read mask", 16'h4100, 0);
    rd_check("R12 read target", 16'h3018, 0);
    rd_check("R12 read info", 16'h0004, 0);
    chk_irq("R12 irq unchanged after reads");

    // Random phase
    for (int it = 0; it < 600; it++) begin
      int op;
      int cpu;
      op = int'($urandom % 7);
      cpu = int'($urandom % C);
      case (op)
        0: begin
          @(negedge clk);
          hw = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        end
        1: wr($urandom % 2 ? 16'h4184 : 16'h4180, $urandom, cpu);
        2: wr($urandom % 2 ? 16'h4104 : 16'h4100, $urandom & $urandom, cpu);
        3: wr($urandom % 2 ? 16'h4000 : 16'h4084, $urandom & $urandom & $urandom, cpu);
        4: wr(16'(16'h3000 + 4 * ($urandom % L)), $urandom, cpu);
        5: evt("R3 random event", cpu);
        default: rd_check("R12 random read", 16'(16'h3000 + 4 * ($urandom % L)), cpu);
      endcase
      chk_irq("R7 random irq");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule